// File: doc/BRIEF.md
# Instrument Status Byte Reporting Unit

This block holds the status and service-request state of a programmable instrument that follows the IEEE 488.2 status model. Level inputs carry the live condition summaries: fault, busy, error queue not empty, questionable summary, message available and operation summary. A set of one-cycle pulses carries the standard events. The block latches those events into an event register, masks them with an event enable register and with a service-request enable register, and builds an eight-bit status byte from the result. It drives a service-request line toward the bus logic.

Host access uses plain strobes. A write strobe loads either enable register. A read strobe with a select code returns the status byte as a query or as a serial poll, or returns the event register or either enable register. `rd_data` is valid combinationally in the cycle `rd_en` is high. There is no back-pressure: every strobe is accepted in the cycle it is presented. The side effects of a read, which clear the event register or the pending request, take effect at the next clock edge. A clear-status strobe empties the event register and drops the pending request.

Top module: `stb_unit`

## Requirements
- R1: After reset the event register, the event enable register and the service-request enable register all read 0, and `srq` is low.
- R2: A status-byte query (`rd_sel`=0) returns bit 7 = `cond_oper`, bit 5 = event summary, bit 4 = `cond_mav`, bit 3 = `cond_ques`, bit 2 = `cond_errq`, bit 1 = `cond_busy` and bit 0 = `cond_fault`. The level bits follow the inputs in the same cycle and are never latched.
- R3: Bit 5 of the status byte is 1 exactly when some event register bit and the same bit of the event enable register (`rd_sel`=3) are both 1.
- R4: On a query, bit 6 is the master summary: the OR over bits 0-5 and 7 of the status byte, each ANDed with the same bit of the service-request enable register (`rd_sel`=4).
- R5: Bit 6 of the service-request enable register ignores writes and always reads 0.
- R6: Each bit of `std_evt` latches into the event register (`rd_sel`=2) and stays set. An event register read returns the value and clears it at the next edge. An event pulse that arrives in the same cycle as that read stays set.
- R7: `cls` clears the event register and the pending service request at the next edge. An event pulse that arrives in the same cycle stays set.
- R8: A rising master summary sets a pending request, which drives `srq` in that same cycle. A serial poll (`rd_sel`=1) returns bit 6 = pending request and clears it at the next edge. A new request needs a fresh rising edge of the summary.
- R9: A write (`wr_sel` 0 = event enable, 1 = service-request enable) takes effect at the next edge. The master summary and `srq` reflect the new mask in the cycle that follows that edge. Read selects 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_fault | input | 1 | Fault condition level |
| cond_busy | input | 1 | Busy condition level |
| cond_errq | input | 1 | Error queue not empty |
| cond_ques | input | 1 | Questionable register summary |
| cond_mav | input | 1 | Message available |
| cond_oper | input | 1 | Operation register summary |
| std_evt | input | 8 | Standard event pulses, one cycle each |
| cls | input | 1 | Clear-status strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 event enable, 1 service-request enable |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 3 | Read source: 0 query, 1 serial poll, 2 events, 3 event enable, 4 service-request enable |
| rd_data | output | 8 | Read data, valid while rd_en is high |
| srq | output | 1 | Service request |

## Verification
All register widths come from the package, and the bench builds the block with those defaults, which are fixed at eight bits by the status byte map. At this width a random phase reaches every enable and event bit, every read select including the unused codes, and the coincident cases. Those include an event arriving on an event read or on a clear, a poll in the same cycle as a rising summary, and a mask write that raises or drops the summary.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int REG_W   = 8;
  localparam int MSS_POS = 6;
  localparam int ESB_POS = 5;
  localparam int N_MASK  = 2;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    RD_QUERY = 3'd0,
    RD_POLL  = 3'd1,
    RD_ESR   = 3'd2,
    RD_ESE   = 3'd3,
    RD_SRE   = 3'd4
  } rd_sel_e;

  localparam logic [REG_W-1:0] SRE_KEEP = ~(REG_W'(1) << MSS_POS);
endpackage

// File: rtl/stb_mask_regs.sv
module stb_mask_regs
  import stb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ese_o,
  output logic [REG_W-1:0] sre_o
);
  logic [REG_W-1:0] regs_q [N_MASK];

  for (genvar g = 0; g < N_MASK; g++) begin : g_mask
    localparam logic [REG_W-1:0] KEEP = (g == 1) ? SRE_KEEP : '1;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[g] <= '0;
      else if (wr_en && (wr_sel == 1'(g)))
        regs_q[g] <= wr_data & KEEP;
    end
  end

  assign ese_o = regs_q[0];
  assign sre_o = regs_q[1];
endmodule

// File: rtl/stb_esr_bank.sv
module stb_esr_bank
  import stb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] evt_i,
  input  logic             clr_i,
  output logic [REG_W-1:0] esr_o
);
  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= (bit_q & ~clr_i) | evt_i[b];
    end
    assign esr_o[b] = bit_q;
  end
endmodule

// File: rtl/stb_srq_ctrl.sv
module stb_srq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mss_i,
  input  logic ack_i,
  output logic rqs_o
);
  logic mss_q;
  logic rqs_q;
  logic rise;

  assign rise  = mss_i & ~mss_q;
  assign rqs_o = rqs_q | rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mss_q <= 1'b0;
      rqs_q <= 1'b0;
    end else begin
      mss_q <= mss_i;
      rqs_q <= ack_i ? 1'b0 : rqs_o;
    end
  end
endmodule

// File: rtl/stb_unit.sv
module stb_unit
  import stb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cond_fault,
  input  logic             cond_busy,
  input  logic             cond_errq,
  input  logic             cond_ques,
  input  logic             cond_mav,
  input  logic             cond_oper,
  input  logic [REG_W-1:0] std_evt,
  input  logic             cls,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             srq
);
  logic [REG_W-1:0] ese_q, sre_q, esr_q, stb_base;
  logic esb, mss, rqs_now, rd_esr, rd_poll;

  assign rd_esr  = rd_en && (rd_sel == RD_ESR);
  assign rd_poll = rd_en && (rd_sel == RD_POLL);

  stb_mask_regs u_masks (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ese_o(ese_q), .sre_o(sre_q)
  );

  stb_esr_bank u_esr (
    .clk(clk), .rst_n(rst_n), .evt_i(std_evt),
    .clr_i(cls | rd_esr), .esr_o(esr_q)
  );

  assign esb = |(esr_q & ese_q);

  always_comb begin
    stb_base = {cond_oper, 1'b0, 1'b0, cond_mav, cond_ques, cond_errq, cond_busy, cond_fault};
    stb_base[ESB_POS] = esb;
  end

  assign mss = |(stb_base & sre_q & SRE_KEEP);

  stb_srq_ctrl u_srq (
    .clk(clk), .rst_n(rst_n), .mss_i(mss),
    .ack_i(rd_poll | cls), .rqs_o(rqs_now)
  );

  assign srq = rqs_now;

  always_comb begin
    rd_data = '0;
    unique case (rd_sel)
      RD_QUERY: begin rd_data = stb_base; rd_data[MSS_POS] = mss;     end
      RD_POLL:  begin rd_data = stb_base; rd_data[MSS_POS] = rqs_now; end
      RD_ESR:   rd_data = esr_q;
      RD_ESE:   rd_data = ese_q;
      RD_SRE:   rd_data = sre_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/stb_unit_chk.sv
module stb_unit_chk
  import stb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [SEL_W-1:0] rd_sel,
  input logic [REG_W-1:0] rd_data,
  input logic             cls,
  input logic [REG_W-1:0] std_evt,
  input logic [REG_W-1:0] esr_q,
  input logic             mss,
  input logic             srq,
  input logic             cond_mav,
  input logic             cond_fault,
  input logic             cond_oper
);
  p_query_levels_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == RD_QUERY) |->
      (rd_data[4] == cond_mav && rd_data[0] == cond_fault && rd_data[7] == cond_oper));

  p_sre_bit6_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == RD_SRE) |-> !rd_data[MSS_POS]);

  p_esr_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|std_evt) |=> ((esr_q & $past(std_evt)) == $past(std_evt)));

  p_cls_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cls && std_evt == '0) |=> (esr_q == '0));

  p_srq_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mss) |-> srq);

  p_poll_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == RD_POLL) |=> (!srq || $rose(mss)));
endmodule

bind stb_unit stb_unit_chk u_chk (.*);

// File: tb/stb_unit_tb_top.sv
module stb_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cond_fault = 0, cond_busy = 0, cond_errq = 0, cond_ques = 0, cond_mav = 0, cond_oper = 0;
  logic [7:0] std_evt = '0;
  logic cls = 0, wr_en = 0, wr_sel = 0, rd_en = 0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic srq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_ese = '0, m_sre = '0, m_esr = '0;
  logic m_rqs = 0, m_mss_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stb_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cond_fault(cond_fault), .cond_busy(cond_busy),
    .cond_errq(cond_errq), .cond_ques(cond_ques), .cond_mav(cond_mav),
    .cond_oper(cond_oper), .std_evt(std_evt), .cls(cls), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .srq(srq)
  );

  function automatic logic [7:0] m_base();
    return {cond_oper, 1'b0, |(m_esr & m_ese), cond_mav, cond_ques, cond_errq, cond_busy, cond_fault};
  endfunction

  function automatic logic m_mss();
    return |(m_base() & m_sre);
  endfunction

  function automatic logic m_srq();
    return m_rqs | (m_mss() && !m_mss_prev);
  endfunction

  function automatic logic [7:0] m_read();
    case (rd_sel)
      3'd0: return m_base() | {1'b0, m_mss(), 6'b0};
      3'd1: return m_base() | {1'b0, m_srq(), 6'b0};
      3'd2: return m_esr;
      3'd3: return m_ese;
      3'd4: return m_sre;
      default: return 8'h00;
    endcase
  endfunction

  task automatic cyc(string tag);
    logic mss_n, eff, clr;
    @(negedge clk);
    checks++;
    if (srq !== m_srq()) begin
      errors++;
      $display("FAIL %s srq actual %b expected %b", tag, srq, m_srq());
    end
    if (rd_en) begin
      checks++;
      if (rd_data !== m_read()) begin
        errors++;
        $display("FAIL %s rd_sel %0d rd_data actual %h expected %h", tag, rd_sel, rd_data, m_read());
      end
    end
    @(posedge clk);
    mss_n = m_mss();
    eff   = m_srq();
    clr   = cls || (rd_en && rd_sel == 3'd2);
    m_rqs = (cls || (rd_en && rd_sel == 3'd1)) ? 1'b0 : eff;
    m_mss_prev = mss_n;
    m_esr = (clr ? 8'h00 : m_esr) | std_evt;
    if (wr_en) begin
      if (wr_sel) m_sre = wr_data & 8'hBF;
      else        m_ese = wr_data;
    end
    #1;
    rd_en = 0; wr_en = 0; cls = 0; std_evt = '0;
  endtask

  task automatic do_read(input logic [2:0] sel, string tag);
    rd_en = 1; rd_sel = sel;
    cyc(tag);
  endtask

  task automatic do_write(input logic sel, input logic [7:0] d, string tag);
    wr_en = 1; wr_sel = sel; wr_data = d;
    cyc(tag);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    do_read(3'd2, "R1");
    do_read(3'd3, "R1");
    do_read(3'd4, "R1");
    do_read(3'd0, "R1");
    // R9, R5: mask writes and bit 6 of service-request enable
    do_write(1'b0, 8'hFF, "R9");
    do_write(1'b1, 8'hFF, "R5");
    do_read(3'd4, "R5");
    do_read(3'd3, "R9");
    do_read(3'd6, "R9");
    // R2, R4, R8: level condition raises summary and request
    cond_fault = 1;
    do_read(3'd0, "R4");
    do_read(3'd1, "R8");
    cyc("R8");
    do_read(3'd1, "R8");
    cond_fault = 0;
    cyc("R8");
    cond_mav = 1; cond_busy = 1;
    do_read(3'd0, "R2");
    cond_mav = 0; cond_busy = 0;
    // R9: mask drop removes summary
    do_write(1'b1, 8'h00, "R9");
    cond_oper = 1;
    do_read(3'd0, "R9");
    cond_oper = 0;
    // R6: event latch and read-clear
    std_evt = 8'h01;
    cyc("R6");
    do_read(3'd2, "R6");
    do_read(3'd2, "R6");
    std_evt = 8'h10;
    cyc("R6");
    std_evt = 8'h02;
    do_read(3'd2, "R6");
    do_read(3'd2, "R6");
    // R7: clear-status with concurrent event
    std_evt = 8'h80;
    cyc("R7");
    cls = 1; std_evt = 8'h08;
    cyc("R7");
    do_read(3'd2, "R7");
    // R3: event summary via enable mask
    do_write(1'b0, 8'h04, "R3");
    std_evt = 8'h02;
    cyc("R3");
    do_read(3'd0, "R3");
    std_evt = 8'h04;
    cyc("R3");
    do_read(3'd0, "R3");
    do_write(1'b1, 8'h20, "R8");
    do_read(3'd1, "R8");
    cls = 1;
    cyc("R7");
    do_read(3'd0, "R7");
    // random traffic
    for (int i = 0; i < 2000; i++) begin
      cond_fault = 1'($urandom); cond_busy = 1'($urandom); cond_errq = 1'($urandom);
      cond_ques = 1'($urandom); cond_mav = 1'($urandom); cond_oper = 1'($urandom);
      std_evt = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      cls = (($urandom % 16) == 0);
      wr_en = (($urandom % 6) == 0); wr_sel = 1'($urandom); wr_data = 8'($urandom);
      rd_en = 1'($urandom); rd_sel = 3'($urandom);
      cyc("R2");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule